// File: doc/BRIEF.md
# Dual-Lane Halfword Averager with Selectable Rounding

This block takes two 32-bit operand words, views each as a pair of signed 16-bit lanes, and returns a 32-bit word. Each lane of the result holds the average of the two matching input lanes. The sum of each lane pair is formed one bit wider than the lanes, so no information is lost before halving. Halving the sum by itself rounds toward minus infinity. When the sum is odd, a rounding stage may add one to that floored value.

Control inputs choose the rounding. A variant input picks between two behaviours. With the variant input low, the block always floors. With it high, a source-select bit chooses which control decides the rounding. One option is a 2-bit mode field that picks nearest, toward zero, toward plus infinity or toward minus infinity. The other option is a single round-up bit.

The datapath has no state apart from an optional output register. It is meant to sit in the execute stage of a media pipeline, next to the logic that decodes the control register.

Top module: `pavg_dual`

## Requirements
- R1: The low result lane (bits 15:0) depends only on bits 15:0 of both operands. The high result lane (bits 31:16) depends only on bits 31:16 of both operands. Rounding in one lane never carries into the other lane.
- R2: Each lane treats its operands as two's-complement 16-bit values and forms their exact 17-bit sum. The result lane is half of that sum, either floored or floored plus one, and it always fits in 16 bits. Example: 0x8000 and 0x8000 give 0x8000, and 0x7FFF and 0x7FFF give 0x7FFF.
- R3: When a lane sum is even, the lane result is exactly half the sum, whatever the control inputs are.
- R4: With `cfg_variant` = 0, every lane result is floor(sum/2). `rnd_src_sel`, `rnd_mode` and `rnd_up` have no effect.
- R5: With `cfg_variant` = 1, `rnd_src_sel` = 1 and `rnd_mode` = 0 (nearest), an odd sum gives floor(sum/2)+1. A half is rounded upward.
- R6: With `cfg_variant` = 1, `rnd_src_sel` = 1 and `rnd_mode` = 1 (toward zero), an odd negative sum gives floor+1 and an odd positive sum gives floor.
- R7: With `cfg_variant` = 1 and `rnd_src_sel` = 1, `rnd_mode` = 2 gives floor+1 on an odd sum (toward plus infinity), and `rnd_mode` = 3 gives floor (toward minus infinity).
- R8: With `cfg_variant` = 1 and `rnd_src_sel` = 0, an odd sum gives floor+1 when `rnd_up` = 1 and floor when `rnd_up` = 0. `rnd_mode` has no effect.
- R9: With `cfg_variant` = 1 and `rnd_src_sel` = 1, `rnd_up` has no effect on the result.
- R10: With REG_OUT = 1 (the default), `avg_word` shows the result for the inputs captured at the previous rising clock edge. While `rst_n` is low, `avg_word` is 0, and reset acts asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low; clears the output register |
| a_word | input | 32 | First operand, two signed 16-bit lanes |
| b_word | input | 32 | Second operand, two signed 16-bit lanes |
| cfg_variant | input | 1 | 0: fixed floor rounding; 1: configurable rounding |
| rnd_src_sel | input | 1 | 1: `rnd_mode` selects rounding; 0: `rnd_up` selects it |
| rnd_mode | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| rnd_up | input | 1 | Used when `rnd_src_sel` = 0: 1 rounds up, 0 floors |
| avg_word | output | 32 | Packed lane averages |

## Verification
The two lanes make their rounding decisions in the same cycle. A bug could let one lane's adjustment leak into the other lane, or let one lane's sign steer the other lane's toward-zero decision. The bench provokes this with operand pairs where both lane sums are odd and of opposite sign, and with a low lane of all ones whose round-up would carry if the lanes were not isolated. It compares each lane against a reference computed in the bench from a truncating division. The output-register timing is checked in the same way by changing the inputs and sampling just before and just after the capturing edge.

// File: rtl/pavg_pkg.sv
package pavg_pkg;

  // Rounding decision resolved from the control inputs.
  typedef enum logic [1:0] {
    RK_FLOOR = 2'd0,
    RK_CEIL  = 2'd1,
    RK_TRUNC = 2'd2,
    RK_NEAR  = 2'd3
  } rnd_kind_e;

endpackage

// File: rtl/pavg_round_sel.sv
module pavg_round_sel
  import pavg_pkg::*;
(
  input  logic       variant_i,
  input  logic       src_sel_i,
  input  logic [1:0] mode_i,
  input  logic       up_i,
  output rnd_kind_e  kind_o
);

  // Map the 2-bit mode field onto a rounding kind.
  function automatic rnd_kind_e kind_from_mode(logic [1:0] m);
    case (m)
      2'd0:    return RK_NEAR;
      2'd1:    return RK_TRUNC;
      2'd2:    return RK_CEIL;
      default: return RK_FLOOR;
    endcase
  endfunction

  always_comb begin
    if (!variant_i) begin
      kind_o = RK_FLOOR;
    end else if (src_sel_i) begin
      kind_o = kind_from_mode(mode_i);
    end else begin
      kind_o = up_i ? RK_CEIL : RK_FLOOR;
    end
  end

endmodule

// File: rtl/pavg_lane.sv
module pavg_lane
  import pavg_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  rnd_kind_e                 kind_i,
  input  logic [LANE_W-1:0]         op_a_i,
  input  logic [LANE_W-1:0]         op_b_i,
  output logic signed [LANE_W:0]    sum_o,
  output logic                      odd_o,
  output logic [LANE_W-1:0]         res_o
);

  localparam int SUM_W = LANE_W + 1;

  // Exact signed sum, one bit wider than a lane.
  function automatic logic signed [SUM_W-1:0] wide_sum(
    logic [LANE_W-1:0] x,
    logic [LANE_W-1:0] y
  );
    return $signed({x[LANE_W-1], x}) + $signed({y[LANE_W-1], y});
  endfunction

  // Whether the floored half needs a +1 for the chosen rounding.
  function automatic logic needs_bump(
    rnd_kind_e               k,
    logic signed [SUM_W-1:0] s
  );
    if (!s[0]) return 1'b0;
    case (k)
      RK_CEIL, RK_NEAR: return 1'b1;
      RK_TRUNC:         return s[SUM_W-1];
      default:          return 1'b0;
    endcase
  endfunction

  logic [LANE_W-1:0] floor_half;
  logic              bump;

  always_comb begin
    sum_o      = wide_sum(op_a_i, op_b_i);
    odd_o      = sum_o[0];
    floor_half = sum_o[SUM_W-1:1];
    bump       = needs_bump(kind_i, sum_o);
    res_o      = floor_half + {{(LANE_W-1){1'b0}}, bump};
  end

  // A bump only occurs on odd sums, whose floored half is below the largest
  // positive lane value, so the increment never wraps.
  always_comb begin
    AST_NO_OVERFLOW: assert (!(bump && floor_half == {1'b0, {(LANE_W-1){1'b1}}})); // R2
  end

endmodule

// File: rtl/pavg_dual.sv
module pavg_dual
  import pavg_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int LANES   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANE_W*LANES-1:0]   a_word,
  input  logic [LANE_W*LANES-1:0]   b_word,
  input  logic                      cfg_variant,
  input  logic                      rnd_src_sel,
  input  logic [1:0]                rnd_mode,
  input  logic                      rnd_up,
  output logic [LANE_W*LANES-1:0]   avg_word
);

  localparam int WORD_W = LANE_W * LANES;
  localparam int DIFF_W = LANE_W + 2;

  rnd_kind_e          kind;
  logic [WORD_W-1:0]  packed_res;

  // Lane-level events brought out for the checks below.
  logic signed [LANE_W:0]   lane_sum   [LANES];
  logic                     lane_odd   [LANES];
  logic [LANE_W-1:0]        lane_res   [LANES];
  logic signed [DIFF_W-1:0] lane_excess [LANES];  // 2*result - sum

  pavg_round_sel u_sel (
    .variant_i (cfg_variant),
    .src_sel_i (rnd_src_sel),
    .mode_i    (rnd_mode),
    .up_i      (rnd_up),
    .kind_o    (kind)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pavg_lane #(.LANE_W(LANE_W)) u_lane (
      .kind_i (kind),
      .op_a_i (a_word[g*LANE_W +: LANE_W]),
      .op_b_i (b_word[g*LANE_W +: LANE_W]),
      .sum_o  (lane_sum[g]),
      .odd_o  (lane_odd[g]),
      .res_o  (lane_res[g])
    );

    assign packed_res[g*LANE_W +: LANE_W] = lane_res[g];
    assign lane_excess[g] = $signed({lane_res[g][LANE_W-1], lane_res[g], 1'b0})
                          - $signed({lane_sum[g][LANE_W], lane_sum[g]});

    AST_EVEN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_odd[g] |-> lane_excess[g] == '0); // R3
    AST_HALF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      lane_odd[g] |-> (lane_excess[g] == 1 || lane_excess[g] == -1)); // R2
    AST_FIXED_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_variant && lane_odd[g]) |-> lane_excess[g] == -1); // R4
    AST_NEAR_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_variant && rnd_src_sel && rnd_mode == 2'd0 && lane_odd[g])
        |-> lane_excess[g] == 1); // R5
    AST_TOWARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_variant && rnd_src_sel && rnd_mode == 2'd1 && lane_odd[g])
        |-> lane_excess[g] == (lane_sum[g] < 0 ? 1 : -1)); // R6
    AST_DIRECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_variant && rnd_src_sel && rnd_mode[1] && lane_odd[g])
        |-> lane_excess[g] == (rnd_mode[0] ? -1 : 1)); // R7
    AST_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_variant && !rnd_src_sel && lane_odd[g])
        |-> lane_excess[g] == (rnd_up ? 1 : -1)); // R8
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) avg_word <= '0;
      else        avg_word <= packed_res;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> avg_word == '0); // R10
  end else begin : g_comb
    assign avg_word = packed_res;
  end

endmodule

// File: tb/pavg_dual_test.sv
module pavg_dual_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_word = '0;
  logic [31:0] b_word = '0;
  logic        cfg_variant = 1'b0;
  logic        rnd_src_sel = 1'b0;
  logic [1:0]  rnd_mode = 2'd0;
  logic        rnd_up = 1'b0;
  logic [31:0] avg_word;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  pavg_dual uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_word      (a_word),
    .b_word      (b_word),
    .cfg_variant (cfg_variant),
    .rnd_src_sel (rnd_src_sel),
    .rnd_mode    (rnd_mode),
    .rnd_up      (rnd_up),
    .avg_word    (avg_word)
  );

  // Reference lane: truncating division, then steer by the remainder.
  function automatic logic [15:0] ref_lane(logic [15:0] x, logic [15:0] y,
                                           logic v, logic s, logic [1:0] m,
                                           logic u);
    int sum, q, r;
    bit go_up;
    sum = int'($signed(x)) + int'($signed(y));
    q = sum / 2;
    r = sum - 2 * q;
    go_up = 1'b0;
    if (v) begin
      if (s) go_up = (m == 2'd0) || (m == 2'd2) || (m == 2'd1 && sum < 0);
      else   go_up = u;
    end
    if (r == 0)      return q[15:0];
    else if (r > 0)  return go_up ? 16'(q + 1) : q[15:0];
    else             return go_up ? q[15:0] : 16'(q - 1);
  endfunction

  function automatic logic [31:0] ref_word(logic [31:0] x, logic [31:0] y,
                                           logic v, logic s, logic [1:0] m,
                                           logic u);
    return {ref_lane(x[31:16], y[31:16], v, s, m, u),
            ref_lane(x[15:0],  y[15:0],  v, s, m, u)};
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    n_checks++;
    if (avg_word !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, avg_word, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge capture, sample at the next fall.
  task automatic run(string tag, logic [31:0] x, logic [31:0] y, logic v,
                     logic s, logic [1:0] m, logic u, logic [31:0] exp);
    a_word = x; b_word = y; cfg_variant = v;
    rnd_src_sel = s; rnd_mode = m; rnd_up = u;
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic run_ref(string tag, logic [31:0] x, logic [31:0] y, logic v,
                         logic s, logic [1:0] m, logic u);
    run(tag, x, y, v, s, m, u, ref_word(x, y, v, s, m, u));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 reset output", 32'h0);
    a_word = 32'h1234_5678; b_word = 32'h1111_1111;
    @(negedge clk);
    check("R10 reset holds", 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_lanes;
    // low: -1 + 0 = -1 odd, rounded up gives 0x0000; high must stay 0x0002
    run("R1 no carry across lanes", 32'h0002_FFFF, 32'h0002_0000, 1, 0, 0, 1, 32'h0002_0000);
    run("R1 lane placement", 32'h0010_0000, 32'h0030_0000, 0, 0, 0, 0, 32'h0020_0000);
    // opposite-sign odd sums, toward zero: high -3 -> -1, low +3 -> 1
    run("R1 R6 mixed-sign lanes", 32'hFFFD_0003, 32'h0000_0000, 1, 1, 1, 0, 32'hFFFF_0001);
  endtask

  task automatic t_extremes;
    run("R2 most negative", 32'h8000_8000, 32'h8000_8000, 1, 1, 2, 0, 32'h8000_8000);
    run("R2 most positive", 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1, 1, 2, 0, 32'h7FFF_7FFF);
    run("R2 odd near top", 32'h7FFF_7FFF, 32'h7FFE_7FFE, 1, 1, 0, 0, 32'h7FFF_7FFF);
    run("R2 mixed extremes", 32'h7FFF_8000, 32'h8000_7FFF, 0, 0, 0, 0, 32'hFFFF_FFFF);
  endtask

  task automatic t_even;
    for (int m = 0; m < 4; m++)
      run("R3 even sum exact", 32'hFFFA_0006, 32'h0000_0002, 1, 1, 2'(m), 1, 32'hFFFD_0004);
  endtask

  task automatic t_fixed;
    for (int k = 0; k < 16; k++)
      run("R4 fixed floor ignores controls", 32'hFFFD_0003, 32'h0000_0000, 0,
          k[0], k[2:1], k[3], 32'hFFFE_0001);
  endtask

  task automatic t_modes;
    run("R5 nearest", 32'hFFFD_0003, 32'h0, 1, 1, 0, 0, 32'hFFFF_0002);
    run("R6 toward zero", 32'hFFFD_0003, 32'h0, 1, 1, 1, 0, 32'hFFFF_0001);
    run("R7 toward plus inf", 32'hFFFD_0003, 32'h0, 1, 1, 2, 0, 32'hFFFF_0002);
    run("R7 toward minus inf", 32'hFFFD_0003, 32'h0, 1, 1, 3, 0, 32'hFFFE_0001);
  endtask

  task automatic t_single_bit;
    for (int m = 0; m < 4; m++) begin
      run("R8 up bit set", 32'hFFFD_0003, 32'h0, 1, 0, 2'(m), 1, 32'hFFFF_0002);
      run("R8 up bit clear", 32'hFFFD_0003, 32'h0, 1, 0, 2'(m), 0, 32'hFFFE_0001);
    end
  endtask

  task automatic t_up_ignored;
    run("R9 up ignored, toward minus inf", 32'hFFFD_0003, 32'h0, 1, 1, 3, 1, 32'hFFFE_0001);
    run("R9 up ignored, toward zero", 32'hFFFD_0003, 32'h0, 1, 1, 1, 1, 32'hFFFF_0001);
  endtask

  task automatic t_latency;
    run("R10 prior value", 32'h0004_0008, 32'h0002_0002, 0, 0, 0, 0, 32'h0003_0005);
    a_word = 32'h0100_0200; b_word = 32'h0100_0200;
    #9;
    check("R10 output holds before edge", 32'h0003_0005);
    @(negedge clk);
    check("R10 output after edge", 32'h0100_0200);
    rst_n = 1'b0;
    #1;
    check("R10 async reset clears", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep;
    logic [31:0] st;
    logic [31:0] x;
    st = 32'h1F2E_3D4C;
    for (int i = 0; i < 192; i++) begin
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
      x = st;
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
      run_ref("R2 sweep", x, st, i[4], i[0], i[2:1], i[3]);
    end
  endtask

  initial begin
    t_reset();
    t_lanes();
    t_extremes();
    t_even();
    t_fixed();
    t_modes();
    t_single_bit();
    t_up_ignored();
    t_latency();
    t_sweep();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #4_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule